// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block sits beside a processor core and decides which interrupt to take at each instruction boundary. It watches five sources. One is non-maskable. Three are restart sources, each with its own fixed vector. The last is a general request that carries no vector of its own. The core pulses `instr_end` in the last clock of every instruction. On that cycle the controller picks the highest-ranked source that is allowed to interrupt, and grants at most one source.

A restart grant, or a grant of the non-maskable source, drives `vec_valid` for one cycle together with the jump address on `vec_addr`. A general grant instead pulls `gen_ack_n` low for one cycle, so that external logic can place a vector on the bus. Software controls the block through a three-bit mask and a global enable.

The global enable is cleared by hardware whenever any maskable source is granted. Software must set it again. The non-maskable source ignores both the mask and the enable. Instruction decode and stack handling are done elsewhere.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `vec_valid` is 0, `gen_ack_n` is 1, the global enable is cleared and all three mask bits are set, so no maskable source can be granted.
- R2: The fixed priority, from highest to lowest, is: non-maskable, top restart (`irq_hi`), middle restart (`irq_mid`), bottom restart (`irq_lo`), general request (`gen_req`).
- R3: The vector addresses are 16'h0024 for the non-maskable source, 16'h003C for `irq_hi`, 16'h0034 for `irq_mid` and 16'h002C for `irq_lo`.
- R4: The non-maskable source arms on a rising edge of `nmi_in`. It is granted at a later boundary only while `nmi_in` is still high, whatever the mask and the enable hold. Once granted, it is not granted again until a new rising edge.
- R5: A rising edge on `irq_hi` sets a pending flag. The flag survives the input falling and survives masking. It clears only when that source is granted.
- R6: `irq_mid` and `irq_lo` are level-sensitive. Each is granted only if its input is high in the boundary cycle.
- R7: A mask bit of 1 blocks its restart source; bit 2 blocks `irq_hi`, bit 1 blocks `irq_mid` and bit 0 blocks `irq_lo`. The general request is gated by the global enable only.
- R8: A general grant drives `gen_ack_n` low for exactly one cycle and leaves `vec_valid` low.
- R9: Granting any maskable source clears the global enable. Granting the non-maskable source leaves the enable unchanged.
- R10: Results appear only in the cycle right after a boundary cycle. At most one source is granted per boundary, and sources that lose stay pending for a later boundary.
- R11: An `ien_set` pulse sets the global enable and an `ien_clr` pulse clears it. A `mask_we` pulse loads `mask_wdata`. Each of these takes effect for boundaries from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_in | input | 1 | Non-maskable request, edge-armed, must stay high |
| irq_hi | input | 1 | Top restart request, edge-captured |
| irq_mid | input | 1 | Middle restart request, level |
| irq_lo | input | 1 | Bottom restart request, level |
| gen_req | input | 1 | General request without a vector |
| instr_end | input | 1 | Instruction-boundary pulse |
| mask_we | input | 1 | Mask load strobe |
| mask_wdata | input | 3 | New mask value (1 = blocked) |
| ien_set | input | 1 | Set the global enable |
| ien_clr | input | 1 | Clear the global enable |
| vec_addr | output | 16 | Vector of the last vectored grant |
| vec_valid | output | 1 | One-cycle pulse: `vec_addr` is a new vector |
| gen_ack_n | output | 1 | Active-low one-cycle acknowledge of a general grant |

## Verification
An edge on `nmi_in` or `irq_hi` is registered one clock before a boundary can see it, so the bench raises these inputs at least one cycle before pulsing `instr_end`. A grant is registered at the clock that ends the boundary cycle. The bench therefore samples `vec_valid`, `vec_addr` and `gen_ack_n` at the falling edge that follows, which is one cycle after the boundary was driven. Mask and enable writes are driven a cycle before the boundary they are meant to affect. A behavioural model updated on each rising edge predicts every output and is compared at every falling edge, alongside directed checks with fixed expected values.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NUM_RST = 3;
  localparam int unsigned NUM_SRC = NUM_RST + 2;
  localparam int unsigned IDX_W   = $clog2(NUM_SRC);
  // source index = rank; higher index wins
  localparam int unsigned SRC_GEN = 0;
  localparam int unsigned SRC_LO  = 1;
  localparam int unsigned SRC_MID = 2;
  localparam int unsigned SRC_HI  = 3;
  localparam int unsigned SRC_NMI = 4;

  // vectors sit at 8*k+4: k=4 for the non-maskable source, k=idx+4 for restarts
  function automatic int unsigned vec_of(input int unsigned idx);
    int unsigned k;
    k = (idx == SRC_NMI) ? 4 : idx + 4;
    return 8 * k + 4;
  endfunction
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/irq_edge_pend.sv
module irq_edge_pend #(
  parameter bit CLR_ON_LOW = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic service,
  output logic pend
);
  logic prev_q, pend_q, pend_d, rise, drop;

  always_comb begin
    rise = din & ~prev_q;
    drop = service | (CLR_ON_LOW & ~din);
    if (rise)      pend_d = 1'b1;
    else if (drop) pend_d = 1'b0;
    else           pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= din;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

  // R5: a pending flag only appears after the input was seen high
  assert_pend_from_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(din));
  // R10: the arbiter serves only a flag that is pending
  assert_service_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    service |-> pend_q);
endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs #(
  parameter int unsigned NUM_RST = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mask_we,
  input  logic [NUM_RST-1:0] mask_wdata,
  input  logic               ien_set,
  input  logic               ien_clr,
  input  logic               grant_maskable,
  output logic [NUM_RST-1:0] mask,
  output logic               ien
);
  logic [NUM_RST-1:0] mask_q, mask_d;
  logic               ien_q, ien_d;

  always_comb begin
    mask_d = mask_we ? mask_wdata : mask_q;
    if (grant_maskable) ien_d = 1'b0;
    else if (ien_set)   ien_d = 1'b1;
    else if (ien_clr)   ien_d = 1'b0;
    else                ien_d = ien_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      ien_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      ien_q  <= ien_d;
    end
  end

  assign mask = mask_q;
  assign ien  = ien_q;

  // R9: a maskable grant leaves the enable cleared
  assert_ien_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    grant_maskable |=> !ien_q);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int unsigned NUM_SRC = 5,
  localparam int unsigned IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               boundary,
  input  logic [NUM_SRC-1:0] req,
  input  logic [NUM_SRC-1:0] allow,
  output logic [NUM_SRC-1:0] gnt,
  output logic [IDX_W-1:0]   gnt_idx,
  output logic               gnt_any
);
  logic [NUM_SRC-1:0] elig;
  logic               found;

  always_comb begin
    elig    = req & allow;
    found   = 1'b0;
    gnt_idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (!found && elig[i]) begin
        found   = 1'b1;
        gnt_idx = IDX_W'(i);
      end
    end
    gnt = '0;
    if (boundary && found) gnt[gnt_idx] = 1'b1;
    gnt_any = boundary & found;
  end

  // R2: the top-ranked eligible source is never passed over
  assert_top_rank_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    boundary && elig[NUM_SRC-1] |-> gnt[NUM_SRC-1]);
  // R10: at most one grant, and only on a boundary
  assert_single_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && (boundary || gnt == '0));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned VEC_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               nmi_in,
  input  logic               irq_hi,
  input  logic               irq_mid,
  input  logic               irq_lo,
  input  logic               gen_req,
  input  logic               instr_end,
  input  logic               mask_we,
  input  logic [NUM_RST-1:0] mask_wdata,
  input  logic               ien_set,
  input  logic               ien_clr,
  output logic [VEC_W-1:0]   vec_addr,
  output logic               vec_valid,
  output logic               gen_ack_n
);
  localparam logic [VEC_W-1:0] NMI_VEC = VEC_W'(vec_of(SRC_NMI));
  localparam logic [VEC_W-1:0] LO_VEC  = VEC_W'(vec_of(SRC_LO));

  logic               rst_i_n;
  logic               nmi_pend, hi_pend;
  logic [NUM_RST-1:0] mask_q;
  logic               ien_q;
  logic [NUM_SRC-1:0] req, allow, gnt;
  logic [IDX_W-1:0]   gnt_idx;
  logic               gnt_any, grant_maskable;
  logic [VEC_W-1:0]   addr_q, addr_d;
  logic               valid_q, valid_d, ackn_q, ackn_d;

  irq_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  irq_edge_pend #(.CLR_ON_LOW(1'b1)) u_nmi (
    .clk(clk), .rst_n(rst_i_n), .din(nmi_in), .service(gnt[SRC_NMI]), .pend(nmi_pend));

  irq_edge_pend #(.CLR_ON_LOW(1'b0)) u_hi (
    .clk(clk), .rst_n(rst_i_n), .din(irq_hi), .service(gnt[SRC_HI]), .pend(hi_pend));

  irq_mask_regs #(.NUM_RST(NUM_RST)) u_regs (
    .clk(clk), .rst_n(rst_i_n), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .ien_set(ien_set), .ien_clr(ien_clr), .grant_maskable(grant_maskable),
    .mask(mask_q), .ien(ien_q));

  always_comb begin
    req[SRC_GEN] = gen_req;
    req[SRC_LO]  = irq_lo;
    req[SRC_MID] = irq_mid;
    req[SRC_HI]  = hi_pend;
    req[SRC_NMI] = nmi_pend & nmi_in;
  end

  assign allow[SRC_GEN] = ien_q;
  assign allow[SRC_NMI] = 1'b1;
  for (genvar g = 0; g < NUM_RST; g++) begin : g_allow
    assign allow[g + 1] = ien_q & ~mask_q[g];
  end

  irq_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .clk(clk), .rst_n(rst_i_n), .boundary(instr_end), .req(req), .allow(allow),
    .gnt(gnt), .gnt_idx(gnt_idx), .gnt_any(gnt_any));

  assign grant_maskable = gnt_any & ~gnt[SRC_NMI];

  always_comb begin
    valid_d = gnt_any & ~gnt[SRC_GEN];
    ackn_d  = ~gnt[SRC_GEN];
    addr_d  = valid_d ? VEC_W'(vec_of(32'(gnt_idx))) : addr_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      addr_q  <= '0;
      valid_q <= 1'b0;
      ackn_q  <= 1'b1;
    end else begin
      addr_q  <= addr_d;
      valid_q <= valid_d;
      ackn_q  <= ackn_d;
    end
  end

  assign vec_addr  = addr_q;
  assign vec_valid = valid_q;
  assign gen_ack_n = ackn_q;

  // R10: outputs pulse only in the cycle after a boundary
  assert_after_boundary_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    (vec_valid || !gen_ack_n) |-> $past(instr_end));
  // R4: an armed, still-high non-maskable request is always taken
  assert_nmi_taken_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    instr_end && nmi_pend && nmi_in |=> vec_valid && vec_addr == NMI_VEC);
  // R7: the bottom restart vector needs enable and a clear mask bit
  assert_lo_unmasked_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(vec_valid) && vec_addr == LO_VEC |-> $past(ien_q && !mask_q[0]));
  // R8: acknowledge and vector never pulse together
  assert_ack_excl_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(vec_valid && !gen_ack_n));
  // R9: after any maskable grant the enable reads cleared
  assert_ien_off_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    ((vec_valid && vec_addr != NMI_VEC) || !gen_ack_n) |-> !ien_q);
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi_in = 0, irq_hi = 0, irq_mid = 0, irq_lo = 0, gen_req = 0;
  logic        instr_end = 0, mask_we = 0, ien_set = 0, ien_clr = 0;
  logic [2:0]  mask_wdata = 3'b000;
  logic [15:0] vec_addr;
  logic        vec_valid, gen_ack_n;

  int    n_tests = 0, n_fail = 0;
  bit    done = 0, live = 0;
  string cur_tag = "R1";

  always #5 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .irq_hi(irq_hi), .irq_mid(irq_mid),
    .irq_lo(irq_lo), .gen_req(gen_req), .instr_end(instr_end), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .ien_set(ien_set), .ien_clr(ien_clr),
    .vec_addr(vec_addr), .vec_valid(vec_valid), .gen_ack_n(gen_ack_n));

  // behavioural reference model
  bit m_nmi_prev, m_nmi_arm, m_hi_prev, m_hi_arm, m_ien;
  bit [2:0] m_mask;
  bit e_valid, e_ackn;
  int e_addr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_nmi_prev = 0; m_nmi_arm = 0; m_hi_prev = 0; m_hi_arm = 0;
      m_ien = 0; m_mask = 3'b111; e_valid = 0; e_ackn = 1; e_addr = 0;
    end else begin
      int pick;
      pick = -1;
      if (instr_end) begin
        if (m_nmi_arm && nmi_in)                 pick = 4;
        else if (m_hi_arm && m_ien && !m_mask[2]) pick = 3;
        else if (irq_mid && m_ien && !m_mask[1])  pick = 2;
        else if (irq_lo && m_ien && !m_mask[0])   pick = 1;
        else if (gen_req && m_ien)                pick = 0;
      end
      e_valid = (pick >= 1);
      e_ackn  = (pick != 0);
      case (pick)
        4: e_addr = 'h24;
        3: e_addr = 'h3C;
        2: e_addr = 'h34;
        1: e_addr = 'h2C;
        default: ;
      endcase
      if (nmi_in && !m_nmi_prev)         m_nmi_arm = 1;
      else if (!nmi_in || pick == 4)     m_nmi_arm = 0;
      if (irq_hi && !m_hi_prev)          m_hi_arm = 1;
      else if (pick == 3)                m_hi_arm = 0;
      if (pick >= 0 && pick <= 3)        m_ien = 0;
      else if (ien_set)                  m_ien = 1;
      else if (ien_clr)                  m_ien = 0;
      if (mask_we) m_mask = mask_wdata;
      m_nmi_prev = nmi_in;
      m_hi_prev  = irq_hi;
    end
  end

  always @(negedge clk) begin
    if (live && !done) begin
      n_tests++;
      if (vec_valid !== e_valid || gen_ack_n !== e_ackn || (e_valid && vec_addr !== 16'(e_addr))) begin
        n_fail++;
        $display("FAIL %s model: valid=%b ackn=%b addr=%h expected valid=%b ackn=%b addr=%h",
                 cur_tag, vec_valid, gen_ack_n, vec_addr, e_valid, e_ackn, 16'(e_addr));
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ien_set();
    ien_set = 1; tick(1); ien_set = 0;
  endtask

  task automatic write_mask(input logic [2:0] m);
    mask_wdata = m; mask_we = 1; tick(1); mask_we = 0;
  endtask

  // kind: 0 nothing, 1 vector, 2 acknowledge
  task automatic bnd(input int kind, input logic [15:0] addr, input string tag);
    instr_end = 1; tick(1); instr_end = 0;
    n_tests++;
    if (vec_valid !== (kind == 1) || gen_ack_n !== (kind != 2) ||
        (kind == 1 && vec_addr !== addr)) begin
      n_fail++;
      $display("FAIL %s: valid=%b ackn=%b addr=%h expected kind=%0d addr=%h",
               tag, vec_valid, gen_ack_n, vec_addr, kind, addr);
    end
    tick(1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1; n_fail++; n_tests++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    tick(2); rst_n = 1; tick(4);
    live = 1;
    cur_tag = "R1";
    n_tests++;
    if (vec_valid !== 1'b0 || gen_ack_n !== 1'b1) begin
      n_fail++;
      $display("FAIL R1: valid=%b ackn=%b expected 0 1", vec_valid, gen_ack_n);
    end
    irq_lo = 1; gen_req = 1; tick(1);
    bnd(0, 16'h0, "R1 reset mask and enable block");
    gen_req = 0;

    cur_tag = "R7";
    pulse_ien_set();
    irq_mid = 1; tick(1);
    bnd(0, 16'h0, "R7 masked mid and lo blocked");
    write_mask(3'b000);
    bnd(1, 16'h0034, "R2 mid over lo");
    cur_tag = "R9";
    bnd(0, 16'h0, "R9 enable cleared after grant");
    pulse_ien_set();
    bnd(1, 16'h0034, "R6 level mid still high");
    irq_mid = 0; pulse_ien_set();
    bnd(1, 16'h002C, "R3 lo vector");
    irq_lo = 0; pulse_ien_set();
    cur_tag = "R6";
    bnd(0, 16'h0, "R6 levels dropped nothing served");

    cur_tag = "R5";
    write_mask(3'b100);
    irq_hi = 1; tick(1); irq_hi = 0; tick(1);
    bnd(0, 16'h0, "R5 hi masked");
    bnd(0, 16'h0, "R5 hi still masked");
    write_mask(3'b011);
    bnd(1, 16'h003C, "R5 hi pending survived");
    pulse_ien_set();
    bnd(0, 16'h0, "R5 hi cleared by service");

    cur_tag = "R11";
    ien_clr = 1; tick(1); ien_clr = 0;
    gen_req = 1; tick(1);
    bnd(0, 16'h0, "R11 enable cleared blocks general");
    cur_tag = "R8";
    pulse_ien_set();
    bnd(2, 16'h0, "R8 general acknowledge");
    bnd(0, 16'h0, "R9 general grant cleared enable");
    gen_req = 0;

    cur_tag = "R4";
    write_mask(3'b111);
    nmi_in = 1; tick(1);
    bnd(1, 16'h0024, "R4 nmi with all blocked");
    bnd(0, 16'h0, "R4 held nmi not repeated");
    nmi_in = 0; tick(1);
    nmi_in = 1; tick(1); nmi_in = 0; tick(1);
    bnd(0, 16'h0, "R4 nmi dropped before boundary");

    cur_tag = "R2";
    write_mask(3'b000);
    pulse_ien_set();
    nmi_in = 1; irq_hi = 1; irq_mid = 1; irq_lo = 1; gen_req = 1; tick(1);
    tick(3);
    cur_tag = "R10";
    n_tests++;
    if (vec_valid !== 1'b0 || gen_ack_n !== 1'b1) begin
      n_fail++;
      $display("FAIL R10 no boundary: valid=%b ackn=%b expected 0 1", vec_valid, gen_ack_n);
    end
    cur_tag = "R2";
    bnd(1, 16'h0024, "R2 nmi first");
    bnd(1, 16'h003C, "R9 nmi kept enable, hi next");
    pulse_ien_set();
    bnd(1, 16'h0034, "R2 mid third");
    irq_mid = 0; pulse_ien_set();
    bnd(1, 16'h002C, "R2 lo fourth");
    irq_lo = 0; pulse_ien_set();
    bnd(2, 16'h0, "R2 general last");
    gen_req = 0; nmi_in = 0; irq_hi = 0;
    tick(3);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule